// File: doc/BRIEF.md
# Conditional move and compare unit

A purely combinational evaluator for integer condition instructions. In move mode it tests operand A against one of eight conditions. It always presents operand B as write data and raises the write enable only when the condition holds, so a false condition leaves the destination register untouched. In compare mode it compares A with B as signed or unsigned 64-bit values. It always writes, and the data is 1 when the relation holds and 0 otherwise.

Operand B comes either from a register value or from an 8-bit literal that is zero-extended. Both instruction kinds share one flag generator: a zero test, a sign bit, a low bit and a single subtractor that yields both orderings. Decode, the register file and any pipelining belong to the surrounding core.

Top module: `cmov_cmp_unit`

## Requirements
- R1: In move mode (`is_cmp_i`=0), `move_cond_i` selects the test on A as a signed two's-complement value. The codes are 0 A==0, 1 A!=0, 2 A<0, 3 A<=0, 4 A>0 and 5 A>=0.
- R2: In move mode, a false condition gives `wr_en_o`=0.
- R3: In move mode, a true condition gives `wr_en_o`=1. In move mode `wr_data_o` always equals the selected B unchanged.
- R4: With `lit_en_i`=1, B is `lit_i` zero-extended to 64 bits, whatever `b_reg_i` holds. With `lit_en_i`=0, B is `b_reg_i`.
- R5: In compare mode (`is_cmp_i`=1), `cmp_fn_i` selects the relation. The codes are 0 A==B, 1 A<B, 2 A<=B, and 3 always false. `cmp_uns_i`=1 selects an unsigned comparison and 0 a signed one.
- R6: In compare mode `wr_en_o` is always 1, and `wr_data_o` is 1 when the relation holds and 0 otherwise, with bits 63..1 always zero.
- R7: An equality compare gives the same result for `cmp_uns_i`=0 and `cmp_uns_i`=1.
- R8: The extreme values order by interpretation. The most negative value 0x8000_0000_0000_0000 and all-ones are below zero when signed and above zero when unsigned. This holds in both the move tests and the compares.
- R9: Move codes 6 (low bit set) and 7 (low bit clear) depend only on bit 0 of A. No other bit of A affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_cmp_i | input | 1 | 1 selects compare mode, 0 selects move mode |
| move_cond_i | input | 3 | Move condition code |
| cmp_fn_i | input | 2 | Compare relation code |
| cmp_uns_i | input | 1 | 1 selects unsigned compare |
| lit_en_i | input | 1 | 1 takes B from the literal |
| a_i | input | 64 | Operand A |
| b_reg_i | input | 64 | Register value for B |
| lit_i | input | 8 | Literal value for B |
| wr_data_o | output | 64 | Write data |
| wr_en_o | output | 1 | Destination write enable |

## Verification
Each move condition is driven with A at zero, at small positive values, at -1 and at the most negative value. This separates the strict tests from the inclusive ones and exposes any test that uses the wrong sign. The low-bit codes are driven with A values whose upper bits contradict bit 0, so a test that reads the wrong bit shows up. Each compare is driven with operand pairs that straddle the sign boundary in both interpretations, so a swapped signed/unsigned path yields a different bit. The literal path is driven with a register B that is all ones, so any leakage into the upper bits is visible.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [2:0] {
    MC_EQ = 3'd0, MC_NE = 3'd1, MC_LT = 3'd2, MC_LE = 3'd3,
    MC_GT = 3'd4, MC_GE = 3'd5, MC_LBS = 3'd6, MC_LBC = 3'd7
  } mcond_e;

  typedef enum logic [1:0] {
    CF_EQ = 2'd0, CF_LT = 2'd1, CF_LE = 2'd2, CF_NONE = 2'd3
  } cfn_e;

  typedef struct packed {
    logic a_zero;
    logic a_neg;
    logic a_lsb;
    logic eq;
    logic lt_s;
    logic lt_u;
  } flags_t;
endpackage

// File: rtl/cmc_bsel.sv
module cmc_bsel #(
  parameter int W  = 64,
  parameter int LW = 8
) (
  input  logic          lit_en_i,
  input  logic [W-1:0]  b_reg_i,
  input  logic [LW-1:0] lit_i,
  output logic [W-1:0]  b_o
);
  localparam int PAD = W - LW;

  generate
    if (PAD > 0) begin : g_pad
      assign b_o = lit_en_i ? {{PAD{1'b0}}, lit_i} : b_reg_i;
      always_comb begin
        if (lit_en_i) p_lit_zext_r4: assert (b_o[W-1:LW] == '0);
      end
    end else begin : g_nopad
      assign b_o = lit_en_i ? lit_i[W-1:0] : b_reg_i;
    end
  endgenerate
endmodule

// File: rtl/cmc_flags.sv
module cmc_flags
  import cmc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output flags_t       flags_o
);
  logic [W:0] diff;

  // one subtractor feeds both orderings
  assign diff          = {1'b0, a_i} - {1'b0, b_i};
  assign flags_o.a_zero = (a_i == '0);
  assign flags_o.a_neg  = a_i[W-1];
  assign flags_o.a_lsb  = a_i[0];
  assign flags_o.eq     = (a_i == b_i);
  assign flags_o.lt_u   = diff[W];
  assign flags_o.lt_s   = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : diff[W-1];

  always_comb begin
    if (flags_o.eq) p_eq_no_order_r7: assert (!flags_o.lt_s && !flags_o.lt_u);
  end
endmodule

// File: rtl/cmc_cond.sv
module cmc_cond
  import cmc_pkg::*;
(
  input  logic [2:0] move_cond_i,
  input  logic [1:0] cmp_fn_i,
  input  logic       cmp_uns_i,
  input  flags_t     flags_i,
  output logic       take_o,
  output logic       cmp_bit_o
);
  logic lt_sel;

  assign lt_sel = cmp_uns_i ? flags_i.lt_u : flags_i.lt_s;

  always_comb begin
    unique case (mcond_e'(move_cond_i))
      MC_EQ:   take_o = flags_i.a_zero;
      MC_NE:   take_o = !flags_i.a_zero;
      MC_LT:   take_o = flags_i.a_neg;
      MC_LE:   take_o = flags_i.a_neg || flags_i.a_zero;
      MC_GT:   take_o = !flags_i.a_neg && !flags_i.a_zero;
      MC_GE:   take_o = !flags_i.a_neg;
      MC_LBS:  take_o = flags_i.a_lsb;
      MC_LBC:  take_o = !flags_i.a_lsb;
      default: take_o = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfn_e'(cmp_fn_i))
      CF_EQ:   cmp_bit_o = flags_i.eq;
      CF_LT:   cmp_bit_o = lt_sel;
      CF_LE:   cmp_bit_o = lt_sel || flags_i.eq;
      default: cmp_bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmov_cmp_unit.sv
module cmov_cmp_unit
  import cmc_pkg::*;
#(
  parameter int W  = 64,
  parameter int LW = 8
) (
  input  logic          is_cmp_i,
  input  logic [2:0]    move_cond_i,
  input  logic [1:0]    cmp_fn_i,
  input  logic          cmp_uns_i,
  input  logic          lit_en_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_reg_i,
  input  logic [LW-1:0] lit_i,
  output logic [W-1:0]  wr_data_o,
  output logic          wr_en_o
);
  logic [W-1:0] b_sel;
  flags_t       flags;
  logic         take;
  logic         cmp_bit;

  cmc_bsel #(.W(W), .LW(LW)) i_bsel (
    .lit_en_i (lit_en_i),
    .b_reg_i  (b_reg_i),
    .lit_i    (lit_i),
    .b_o      (b_sel)
  );

  cmc_flags #(.W(W)) i_flags (
    .a_i     (a_i),
    .b_i     (b_sel),
    .flags_o (flags)
  );

  cmc_cond i_cond (
    .move_cond_i (move_cond_i),
    .cmp_fn_i    (cmp_fn_i),
    .cmp_uns_i   (cmp_uns_i),
    .flags_i     (flags),
    .take_o      (take),
    .cmp_bit_o   (cmp_bit)
  );

  assign wr_en_o   = is_cmp_i | take;
  assign wr_data_o = is_cmp_i ? {{(W-1){1'b0}}, cmp_bit} : b_sel;

  always_comb begin
    if (is_cmp_i) p_cmp_form_r6: assert (wr_en_o && wr_data_o[W-1:1] == '0);
    if (!is_cmp_i) p_move_pass_r3: assert (wr_data_o == b_sel);
    if (!is_cmp_i && move_cond_i == MC_EQ) p_eq_zero_r1: assert (wr_en_o == (a_i == '0));
    if (!is_cmp_i && move_cond_i == MC_LBS) p_lbs_bit0_r9: assert (wr_en_o == a_i[0]);
  end
endmodule

// File: tb/test_cmov_cmp_unit.sv
module test_cmov_cmp_unit;
  typedef struct packed {
    logic [3:0]  req;
    logic        is_cmp;
    logic [2:0]  cond;
    logic [1:0]  fn;
    logic        uns;
    logic        lit_en;
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  lit;
    logic        exp_en;
    logic [63:0] exp_d;
  } vec_t;

  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] BV   = 64'h0000_1234_5678_9ABC;
  localparam int NV = 28;

  // req, cmp, cond, fn, uns, lit, a, b, lit, en, data
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64'd0, BV, 8'h00, 1'b1, BV},      // R1 eq true
    '{4'd2, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 64'd1, BV, 8'h00, 1'b0, BV},      // R2 eq false
    '{4'd1, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd5, BV, 8'h00, 1'b1, BV},      // R1 ne
    '{4'd2, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd0, BV, 8'h00, 1'b0, BV},      // R2 ne false
    '{4'd8, 1'b0, 3'd2, 2'd0, 1'b0, 1'b0, MINN,  BV, 8'h00, 1'b1, BV},      // R8 lt min
    '{4'd2, 1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 64'd0, BV, 8'h00, 1'b0, BV},      // R2 lt zero
    '{4'd1, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 64'd0, BV, 8'h00, 1'b1, BV},      // R1 le zero
    '{4'd2, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 64'd1, BV, 8'h00, 1'b0, BV},      // R2 le one
    '{4'd1, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0, 64'd1, BV, 8'h00, 1'b1, BV},      // R1 gt one
    '{4'd8, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0, ONES,  BV, 8'h00, 1'b0, BV},      // R8 gt -1
    '{4'd2, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0, 64'd0, BV, 8'h00, 1'b0, BV},      // R2 gt zero
    '{4'd8, 1'b0, 3'd5, 2'd0, 1'b0, 1'b0, MINN,  BV, 8'h00, 1'b0, BV},      // R8 ge min
    '{4'd1, 1'b0, 3'd5, 2'd0, 1'b0, 1'b0, 64'd0, BV, 8'h00, 1'b1, BV},      // R1 ge zero
    '{4'd9, 1'b0, 3'd6, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, BV, 8'h00, 1'b0, BV}, // R9
    '{4'd9, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, BV, 8'h00, 1'b1, BV}, // R9
    '{4'd9, 1'b0, 3'd6, 2'd0, 1'b0, 1'b0, 64'd1, BV, 8'h00, 1'b1, BV},      // R9 lbs
    '{4'd4, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'd1, ONES, 8'hAB, 1'b1, 64'hAB}, // R4 literal
    '{4'd7, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, ONES,  ONES, 8'h00, 1'b1, 64'd1}, // R7 eq s
    '{4'd7, 1'b1, 3'd0, 2'd0, 1'b1, 1'b0, ONES,  ONES, 8'h00, 1'b1, 64'd1}, // R7 eq u
    '{4'd8, 1'b1, 3'd0, 2'd1, 1'b0, 1'b0, MINN,  64'd0, 8'h00, 1'b1, 64'd1}, // R8 lt s
    '{4'd8, 1'b1, 3'd0, 2'd1, 1'b1, 1'b0, MINN,  64'd0, 8'h00, 1'b1, 64'd0}, // R8 lt u
    '{4'd8, 1'b1, 3'd0, 2'd1, 1'b0, 1'b0, ONES,  64'd0, 8'h00, 1'b1, 64'd1}, // R8 -1<0 s
    '{4'd8, 1'b1, 3'd0, 2'd2, 1'b1, 1'b0, ONES,  64'd0, 8'h00, 1'b1, 64'd0}, // R8 le u
    '{4'd5, 1'b1, 3'd0, 2'd2, 1'b0, 1'b0, 64'd5, 64'd5, 8'h00, 1'b1, 64'd1}, // R5 le eq
    '{4'd5, 1'b1, 3'd0, 2'd1, 1'b0, 1'b0, 64'd5, 64'd5, 8'h00, 1'b1, 64'd0}, // R5 lt eq
    '{4'd4, 1'b1, 3'd0, 2'd2, 1'b1, 1'b1, 64'h10, ONES, 8'h0F, 1'b1, 64'd0}, // R4 lit le
    '{4'd6, 1'b1, 3'd0, 2'd3, 1'b0, 1'b0, 64'd3, 64'd3, 8'h00, 1'b1, 64'd0}, // R6 code 3
    '{4'd5, 1'b1, 3'd0, 2'd1, 1'b1, 1'b0, MAXP,  MINN, 8'h00, 1'b1, 64'd1}  // R5 lt u
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic        is_cmp, uns, lit_en;
  logic [2:0]  cond;
  logic [1:0]  fn;
  logic [63:0] a, b;
  logic [7:0]  lit;
  logic [63:0] wr_data;
  logic        wr_en;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmov_cmp_unit i_cmov_cmp_unit (
    .is_cmp_i (is_cmp), .move_cond_i (cond), .cmp_fn_i (fn), .cmp_uns_i (uns),
    .lit_en_i (lit_en), .a_i (a), .b_reg_i (b), .lit_i (lit),
    .wr_data_o (wr_data), .wr_en_o (wr_en)
  );

  task automatic drive(input vec_t v);
    @(posedge clk); #2;
    is_cmp = v.is_cmp; cond = v.cond; fn = v.fn; uns = v.uns;
    lit_en = v.lit_en; a = v.a; b = v.b; lit = v.lit;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic exp_en, input logic [63:0] exp_d);
    n_chk++;
    if (wr_en !== exp_en || wr_data !== exp_d) begin
      n_bad++;
      $display("FAIL R%0d: en=%0b data=%h expected en=%0b data=%h", req, wr_en, wr_data, exp_en, exp_d);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    is_cmp = 0; cond = 0; fn = 0; uns = 0; lit_en = 0; a = '0; b = '0; lit = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(1, 1'b1, 64'd0);  // R1 idle inputs: eq zero taken, B=0

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check(int'(TBL[i].req), TBL[i].exp_en, TBL[i].exp_d);
    end

    // R4: literal ignores register B, upper bits stay zero
    for (int k = 0; k < 256; k += 51) begin
      drive('{4'd4, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 64'd0, ONES, 8'(k), 1'b1, 64'(k)});
      check(4, 1'b1, 64'(k));
    end

    // R7: equality identical signed vs unsigned across sign boundary
    for (int k = 0; k < 4; k++) begin
      logic [63:0] x;
      x = (k == 0) ? MINN : (k == 1) ? MAXP : (k == 2) ? ONES : 64'd0;
      for (int u = 0; u < 2; u++) begin
        drive('{4'd7, 1'b1, 3'd0, 2'd0, 1'(u), 1'b0, x, x, 8'h00, 1'b1, 64'd1});
        check(7, 1'b1, 64'd1);
        drive('{4'd7, 1'b1, 3'd0, 2'd0, 1'(u), 1'b0, x, ~x, 8'h00, 1'b1, 64'd0});
        check(7, 1'b1, 64'd0);
      end
    end

    // R9: upper bits of A do not affect low-bit tests
    drive('{4'd9, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0, MINN, BV, 8'h00, 1'b1, BV});
    check(9, 1'b1, BV);
    drive('{4'd9, 1'b0, 3'd6, 2'd0, 1'b0, 1'b0, 64'h8000_0000_0000_0001, BV, 8'h00, 1'b1, BV});
    check(9, 1'b1, BV);

    finish_run();
  end
endmodule